// File: doc/BRIEF.md
# Strobe-Latched Ten-Bit Serial Link Transmitter

This block turns a ten-bit parallel word into a serial bit stream for a narrow board-to-board link. A rising edge on the strobe input captures the word. The word then goes out on one serial data line, together with a forwarded serial clock that changes state once per bit slot. The block runs entirely from a bit-rate clock, which stands in for a locked frequency multiplier at twelve times the reference rate. Every twelve bit clocks make one frame: ten data slots and two framing slots. The framing slots tell the receiver whether the frame carries a fresh word or is filler.

A two-bit rate code sets how many frames one strobe period spans: one, two or three. From this the block produces a word clock for the far side, low for the first half of that span and high for the second half. A separate two-bit range code set to zero puts the block into power-down. Power-down clears every register, ignores the parallel inputs and the strobe, and parks the outputs at fixed levels. The block also drives the inverse of its direction input, so a paired receiver can be turned around.

Top module: `sertx_top`

## Requirements
- R1: Every clock edge counts as edge k, where k is the number of edges since reset release or since the last power-down edge. A strobe that is sampled high at edge k and was sampled low one edge earlier latches the parallel word. The word goes out in frame floor(k/12)+1, where frame f covers the states after edges 12f to 12f+11. A frame that starts on the capture edge itself does not carry the new word.
- R2: In a data frame, the state after edge 12f+s (s = 0..9) drives data bit s on ser_data_o. Bits go out least significant first.
- R3: In a data frame, position s = 10 carries 1 and s = 11 carries 0. In a frame with no word, positions 0..9 are 0, position 10 is 0 and position 11 is 1.
- R4: A strobe held high captures only once. Each captured word is sent in exactly one frame, and the following frames are filler until the next rising edge.
- R5: When two strobe edges fall before the same frame start, the later word is sent and the earlier one is dropped.
- R6: The rate code gives the frame count N per strobe period: 2'b00 or 2'b01 gives N = 1, 2'b10 gives N = 2, and 2'b11 gives N = 3. word_clk_o is 0 while (frame index mod N)*12 + s < 6N, and 1 otherwise.
- R7: When range_sel_i == 2'b00, the next edge clears all state and enters power-down. While in power-down, word_clk_o = 1, ser_clk_o = 0 and ser_data_o = 0, and strobe edges are lost. The first edge with a nonzero range code restarts the timing exactly as a reset release does.
- R8: ser_clk_o is 0 in the reset state and inverts on every clock edge outside power-down, so its value after edge k is k mod 2.
- R9: dir_n_o is always the logical inverse of dir_i.
- R10: An asynchronous low rst_ni forces ser_clk_o = 0, ser_data_o = 0 and word_clk_o = 0 (the start of the word-clock low half).

Power-down is taken from the range code only. The rate code is not involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock, twelve slots per reference period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| range_sel_i | input | 2 | Range code; 2'b00 selects power-down |
| rate_sel_i | input | 2 | Strobe-to-reference ratio code |
| dir_i | input | 1 | Link direction input |
| strobe_i | input | 1 | Word strobe, rising edge latches data |
| par_data_i | input | 10 | Parallel word |
| ser_data_o | output | 1 | Serial data, one bit per slot |
| ser_clk_o | output | 1 | Forwarded serial clock |
| word_clk_o | output | 1 | Word clock for the far side |
| dir_n_o | output | 1 | Inverse of dir_i |

## Verification
The bench moves the strobe edge across all twelve slot positions. This exposes an off-by-one in the capture-to-frame mapping: a design that loads a word captured on the frame-start edge itself would send it one frame early. Two edges inside one frame catch a design that keeps the first word instead of the last. A strobe held high for several frames catches level-sensitive capture, which would send the same word over and over. Sweeps in each rate mode, with the mode changed during power-down, catch a wrong word-clock period or duty. Strobes pulsed during power-down catch a design that keeps a word latched while asleep and sends it after waking.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    parameter int unsigned SERTX_DATA_W    = 10;
    parameter int unsigned SERTX_FRAME_PAD = 2;
    parameter int unsigned SERTX_MAX_RATIO = 3;

    typedef enum logic [1:0] {
        RATE_SAME_SS = 2'b00,
        RATE_SAME    = 2'b01,
        RATE_HALF    = 2'b10,
        RATE_THIRD   = 2'b11
    } rate_e;

    // Frames spanned by one strobe period for a rate code
    function automatic int unsigned frames_per_word(input logic [1:0] code);
        case (rate_e'(code))
            RATE_HALF:  return 2;
            RATE_THIRD: return 3;
            default:    return 1;
        endcase
    endfunction

endpackage

// File: rtl/sertx_slot_timer.sv
module sertx_slot_timer
    import sertx_pkg::*;
#(
    parameter int unsigned SLOTS     = 12,
    parameter int unsigned MAX_RATIO = 3,
    parameter int unsigned SLOT_W    = $clog2(SLOTS),
    parameter int unsigned PHASE_W   = $clog2(MAX_RATIO + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pd_i,
    input  logic [1:0]        rate_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              frame_end_o,
    output logic              pd_q_o,
    output logic              ser_clk_o,
    output logic              word_clk_o
);

    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        logic [PHASE_W-1:0] phase;
        logic               asleep;
        logic               sclk;
    } tmr_t;

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    tmr_t        tmr_d, tmr_q;
    int unsigned ratio;
    int unsigned pos;

    always_comb begin
        ratio = frames_per_word(rate_i);
        pos   = 32'(tmr_q.phase) * SLOTS + 32'(tmr_q.slot);
        tmr_d = tmr_q;
        if (pd_i) begin
            tmr_d        = '0;
            tmr_d.asleep = 1'b1;
        end else begin
            tmr_d.asleep = 1'b0;
            tmr_d.sclk   = ~tmr_q.sclk;
            if (tmr_q.slot == LAST_SLOT) begin
                tmr_d.slot = '0;
                if (32'(tmr_q.phase) + 32'd1 >= ratio) begin
                    tmr_d.phase = '0;
                end else begin
                    tmr_d.phase = tmr_q.phase + 1'b1;
                end
            end else begin
                tmr_d.slot = tmr_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign slot_o      = tmr_q.slot;
    assign frame_end_o = (tmr_q.slot == LAST_SLOT);
    assign pd_q_o      = tmr_q.asleep;
    assign ser_clk_o   = tmr_q.sclk;
    assign word_clk_o  = tmr_q.asleep | (pos >= (ratio * SLOTS) / 2);

endmodule

// File: rtl/sertx_strobe_capture.sv
module sertx_strobe_capture #(
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pd_i,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] word_o,
    output logic              valid_o
);

    typedef struct packed {
        logic              prev;
        logic              valid;
        logic [DATA_W-1:0] word;
    } cap_t;

    cap_t cap_d, cap_q;
    logic rise;

    always_comb begin
        rise  = strobe_i & ~cap_q.prev;
        cap_d = cap_q;
        if (pd_i) begin
            cap_d = '0;
        end else begin
            cap_d.prev = strobe_i;
            if (rise) begin
                cap_d.word  = data_i;
                cap_d.valid = 1'b1;
            end else if (take_i) begin
                cap_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign word_o  = cap_q.word;
    assign valid_o = cap_q.valid;

endmodule

// File: rtl/sertx_frame_shifter.sv
module sertx_frame_shifter #(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned SLOTS  = DATA_W + 2,
    parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pd_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              valid_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              ser_data_o
);

    localparam logic [SLOTS-1:0] IDLE_FRAME = {1'b1, {(SLOTS - 1){1'b0}}};

    typedef struct packed {
        logic [SLOTS-1:0] bits;
    } frm_t;

    frm_t frm_d, frm_q;

    always_comb begin
        frm_d = frm_q;
        if (pd_i) begin
            frm_d.bits = IDLE_FRAME;
        end else if (load_i) begin
            if (valid_i) begin
                frm_d.bits = {1'b0, 1'b1, word_i};
            end else begin
                frm_d.bits = IDLE_FRAME;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            frm_q.bits <= IDLE_FRAME;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign ser_data_o = frm_q.bits[slot_i];

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_W    = SERTX_DATA_W,
    parameter int unsigned MAX_RATIO = SERTX_MAX_RATIO
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        range_sel_i,
    input  logic [1:0]        rate_sel_i,
    input  logic              dir_i,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] par_data_i,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              word_clk_o,
    output logic              dir_n_o
);

    localparam int unsigned SLOTS  = DATA_W + SERTX_FRAME_PAD;
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    logic              pd_w;
    logic [SLOT_W-1:0] slot_w;
    logic              frame_end_w;
    logic              pd_q_w;
    logic [DATA_W-1:0] word_w;
    logic              valid_w;

    assign pd_w    = (range_sel_i == 2'b00);
    assign dir_n_o = ~dir_i;

    sertx_slot_timer #(
        .SLOTS     (SLOTS),
        .MAX_RATIO (MAX_RATIO),
        .SLOT_W    (SLOT_W)
    ) timer_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pd_i        (pd_w),
        .rate_i      (rate_sel_i),
        .slot_o      (slot_w),
        .frame_end_o (frame_end_w),
        .pd_q_o      (pd_q_w),
        .ser_clk_o   (ser_clk_o),
        .word_clk_o  (word_clk_o)
    );

    sertx_strobe_capture #(
        .DATA_W (DATA_W)
    ) capture_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pd_i     (pd_w),
        .strobe_i (strobe_i),
        .data_i   (par_data_i),
        .take_i   (frame_end_w),
        .word_o   (word_w),
        .valid_o  (valid_w)
    );

    sertx_frame_shifter #(
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W)
    ) shifter_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pd_i       (pd_w),
        .load_i     (frame_end_w),
        .word_i     (word_w),
        .valid_i    (valid_w),
        .slot_i     (slot_w),
        .ser_data_o (ser_data_o)
    );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int unsigned SLOT_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [1:0]        range_sel_i,
    input logic              dir_i,
    input logic              dir_n_o,
    input logic              ser_data_o,
    input logic              ser_clk_o,
    input logic              word_clk_o,
    input logic [SLOT_W-1:0] slot_i,
    input logic              pd_q_i
);

    // R7
    sleep_levels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (range_sel_i == 2'b00) |=> (word_clk_o && !ser_clk_o && !ser_data_o));

    // R8
    sclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (range_sel_i != 2'b00) |=> (ser_clk_o != $past(ser_clk_o)));

    // R9
    dir_invert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dir_n_o != dir_i);

    // R3
    framing_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_i == SLOT_W'(11) && !pd_q_i) |-> (ser_data_o != $past(ser_data_o)));

    // R6
    wclk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pd_q_i && $rose(word_clk_o)) |-> (slot_i == SLOT_W'(6) || slot_i == '0));

endmodule

bind sertx_top sertx_chk #(
    .SLOT_W (SLOT_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .range_sel_i (range_sel_i),
    .dir_i       (dir_i),
    .dir_n_o     (dir_n_o),
    .ser_data_o  (ser_data_o),
    .ser_clk_o   (ser_clk_o),
    .word_clk_o  (word_clk_o),
    .slot_i      (slot_w),
    .pd_q_i      (pd_q_w)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 10;
    localparam int SLOTS      = 12;
    localparam int NFR        = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    range_sel = 2'b01;
    logic [1:0]    rate_sel = 2'b01;
    logic          dir = 1'b1;
    logic          strobe = 1'b0;
    logic [DW-1:0] pdata = '0;
    logic          ser_data, ser_clk, word_clk, dir_n;

    sertx_top dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .range_sel_i (range_sel),
        .rate_sel_i  (rate_sel),
        .dir_i       (dir),
        .strobe_i    (strobe),
        .par_data_i  (pdata),
        .ser_data_o  (ser_data),
        .ser_clk_o   (ser_clk),
        .word_clk_o  (word_clk),
        .dir_n_o     (dir_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int            checks = 0;
    int            errors = 0;
    string         tag = "R1";
    int            k = 0;
    bit            pd_last = 1'b0;
    bit            mon_en = 1'b0;
    logic          stb_prev_b = 1'b0;
    logic [DW-1:0] exp_word [NFR];
    bit            exp_val  [NFR];

    function automatic int ratio_of(input logic [1:0] c);
        if (c == 2'b10) return 2;
        if (c == 2'b11) return 3;
        return 1;
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (edge %0d)", req, got, exp, k);
        end
    endtask

    // Reference: edge count since reset/power-down and the expected frame contents
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || range_sel == 2'b00) begin
            k          <= 0;
            pd_last    <= rst_n;
            stb_prev_b <= 1'b0;
            for (int i = 0; i < NFR; i++) begin
                exp_val[i]  <= 1'b0;
                exp_word[i] <= '0;
            end
        end else begin
            k          <= k + 1;
            pd_last    <= 1'b0;
            stb_prev_b <= strobe;
            if (strobe && !stb_prev_b) begin
                exp_word[(k + 1) / SLOTS + 1] <= pdata;
                exp_val[(k + 1) / SLOTS + 1]  <= 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !pd_last && mon_en) begin
            automatic int f = k / SLOTS;
            automatic int s = k % SLOTS;
            automatic int n = ratio_of(rate_sel);
            automatic int pos = ((f % n) * SLOTS) + s;
            automatic logic e;
            if (s < DW)       e = exp_val[f] & exp_word[f][s];
            else if (s == DW) e = exp_val[f];
            else              e = ~exp_val[f];
            if (s < DW) chk({tag, " R1 R2 data slot"}, ser_data, e);
            else        chk({tag, " R3 framing slot"}, ser_data, e);
            chk("R6 word clock", word_clk, logic'(pos >= 6 * n));
            chk("R8 serial clock", ser_clk, logic'(k % 2));
            chk("R9 direction", dir_n, ~dir);
        end
    end

    task automatic pulse(input logic [DW-1:0] w);
        @(negedge clk);
        pdata  = w;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        pdata  = ~w;
    endtask

    task automatic wait_slot(input int s);
        @(negedge clk);
        while (k % SLOTS != s) @(negedge clk);
    endtask

    task automatic sweep(input int count, input int base_gap);
        for (int i = 0; i < count; i++) begin
            automatic logic [DW-1:0] w = DW'((i * 389 + 123) % 1024);
            if (i == 0) w = 10'h3FF;
            if (i == 1) w = 10'h000;
            if (i == 2) w = 10'h155;
            if (i == 3) w = 10'h2AA;
            pulse(w);
            repeat (base_gap + (i * 7) % 23) @(negedge clk);
            if (i % 9 == 4) dir = ~dir;
        end
        repeat (3 * SLOTS * 3) @(negedge clk);
    endtask

    task automatic sleep_and_wake(input logic [1:0] new_rate, input logic [1:0] wake_range);
        @(negedge clk);
        range_sel = 2'b00;
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i == 3) begin pdata = 10'h1A5; strobe = 1'b1; end
            if (i == 5) strobe = 1'b0;
            if (i == 6) rate_sel = new_rate;
            #1;
            // R7: fixed levels while asleep, strobe ignored
            chk("R7 sleep word clock", word_clk, 1'b1);
            chk("R7 sleep serial clock", ser_clk, 1'b0);
            chk("R7 sleep data", ser_data, 1'b0);
        end
        @(negedge clk);
        tag = "R7";
        range_sel = wake_range;
        repeat (3 * SLOTS * 3) @(negedge clk);
    endtask

    initial begin
        #1;
        // R10: reset state
        chk("R10 reset serial clock", ser_clk, 1'b0);
        chk("R10 reset data", ser_data, 1'b0);
        chk("R10 reset word clock", word_clk, 1'b0);
        chk("R9 reset direction", dir_n, 1'b0);
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        mon_en = 1'b1;

        // R1: strobe edge placed at every slot position, including frame start
        tag = "R1";
        for (int s = 0; s < SLOTS; s++) begin
            wait_slot(s);
            pdata  = DW'(10'h0F0 ^ (s * 37));
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
            repeat (SLOTS + 5) @(negedge clk);
        end

        // R5: two edges inside one frame, the later word must win
        tag = "R5";
        for (int r = 0; r < 4; r++) begin
            wait_slot(1 + r);
            pulse(10'h00F + 10'(r));
            pulse(10'h3C0 - 10'(r));
            repeat (2 * SLOTS) @(negedge clk);
        end

        // R4: strobe held high for several frames with changing data
        tag = "R4";
        @(negedge clk);
        pdata  = 10'h2D3;
        strobe = 1'b1;
        for (int i = 0; i < 5 * SLOTS; i++) begin
            @(negedge clk);
            pdata = DW'(i * 91);
        end
        strobe = 1'b0;
        repeat (3 * SLOTS) @(negedge clk);

        tag = "R2";
        sweep(30, 3);

        sleep_and_wake(2'b10, 2'b11);
        tag = "R6";
        sweep(24, 2 * SLOTS - 6);

        sleep_and_wake(2'b11, 2'b10);
        tag = "R6";
        sweep(24, 3 * SLOTS - 8);

        sleep_and_wake(2'b00, 2'b01);
        tag = "R2";
        sweep(24, 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule